// File: doc/BRIEF.md
# Sink-Peeling Cycle Detector

This block decides whether a directed graph of up to `P` nodes contains a cycle. The adjacency matrix is written one row per node through a simple load port. A start pulse then selects which nodes take part, through a node mask. The block strips away every node that has no outgoing arc to a surviving node, all of them in the same step, and repeats this once per clock cycle.

The run ends in one of two ways. Either every node has been removed, which means the graph is acyclic, or a step finds nothing to remove while nodes remain, which means a cycle exists. For an acyclic graph the number of steps taken equals the longest path length plus one. This is the memory order of the finite-state machine whose pair-successor graph was loaded. A one-cycle done pulse marks the moment the loop flag and step count become valid. Both results are held until the next run begins.

Top module: `dag_round_checker`

## Requirements
- R1: Asserting `ld_en_i` while idle stores `ld_row_i` as the row of node `ld_idx_i`; bit j of that row set to 1 means an arc from that node to node j. A load presented while `busy_o` is high is discarded.
- R2: A surviving node is a sink when none of the arcs in its row point at a surviving node; arcs towards nodes outside the start mask are not counted.
- R3: Each busy cycle removes all current sinks at once and adds one to the step count, which starts at 0 at start.
- R4: When a step finds no sink and surviving nodes remain, `done_o` pulses with `loop_o` = 1 in that same cycle.
- R5: When the last surviving nodes are removed, `done_o` pulses with `loop_o` = 0 and `order_o` equal to the number of steps. For an acyclic run of k steps this is exactly k cycles after the start cycle.
- R6: The six-node graph with rows (node 0 first, bit j = arc to node j) 0x28, 0x14, 0x10, 0x22, 0x20, 0x00 ends with `loop_o` = 0 and `order_o` = 6.
- R7: A node with an arc to itself never becomes a sink, so any run that includes it reports a loop.
- R8: A start with an all-zero node mask gives `done_o` in the following cycle, with `loop_o` = 0 and `order_o` = 0, and `busy_o` never rises.
- R9: A start pulse while `busy_o` is high is ignored; the running check finishes with its own result.
- R10: `done_o` is high for exactly one cycle and never together with `busy_o`. `loop_o` and `order_o` hold their values until the next accepted start.
- R11: After reset, `busy_o`, `done_o`, `loop_o` and `order_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en_i | input | 1 | Write one adjacency row |
| ld_idx_i | input | $clog2(P) | Node whose row is written |
| ld_row_i | input | P | Row data, bit j = arc to node j |
| start_i | input | 1 | Begin a check (one-cycle pulse) |
| node_mask_i | input | P | Nodes taking part, sampled at start |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| loop_o | output | 1 | 1 when a cycle was found |
| order_o | output | $clog2(P+1) | Number of removal steps |

## Verification
The assertions check the shape of the handshake on every cycle. They cover that done is a single-cycle pulse exclusive of busy, that a busy period only ends through done, that the results stay stable while idle, and that an acyclic count never exceeds P. Whether a given graph is judged cyclic, and with which step count and latency, can only be shown by the bench's graphs. The same holds for the rules about loads and starts being ignored while busy, and for masked-out arcs and self-arcs. These graphs are the worked six-node case, a full chain, a diamond, and cycles that appear immediately or only after some peeling.

// File: rtl/dag_round_pkg.sv
package dag_round_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEEL = 1'b1
  } peel_state_e;
endpackage

// File: rtl/adj_row_store.sv
module adj_row_store #(
  parameter int P  = 8,
  parameter int IW = (P > 1) ? $clog2(P) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [IW-1:0]         widx_i,
  input  logic [P-1:0]          wrow_i,
  output logic [P-1:0][P-1:0]   rows_o
);
  logic [P-1:0][P-1:0] mem_q;

  // every row is read in parallel each step, so the store is a flat register bank
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (we_i && (int'(widx_i) < P)) begin
      mem_q[widx_i] <= wrow_i;
    end
  end

  assign rows_o = mem_q;
endmodule

// File: rtl/sink_finder.sv
module sink_finder #(
  parameter int P = 8
) (
  input  logic [P-1:0][P-1:0] rows_i,
  input  logic [P-1:0]        alive_i,
  output logic [P-1:0]        sinks_o
);
  for (genvar n = 0; n < P; n++) begin : g_node
    // a surviving node with no arc into the surviving set
    assign sinks_o[n] = alive_i[n] & ~(|(rows_i[n] & alive_i));
  end
endmodule

// File: rtl/peel_ctrl.sv
module peel_ctrl
  import dag_round_pkg::*;
#(
  parameter int P  = 8,
  parameter int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [P-1:0]  mask_i,
  input  logic [P-1:0]  sinks_i,
  output logic [P-1:0]  alive_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          loop_o,
  output logic [CW-1:0] order_o
);
  peel_state_e   st_q;
  logic [P-1:0]  alive_q;
  logic [CW-1:0] step_q;
  logic [P-1:0]  left_d;
  logic [CW-1:0] step_inc;

  assign left_d   = alive_q & ~sinks_i;
  assign step_inc = step_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      alive_q <= '0;
      step_q  <= '0;
      done_o  <= 1'b0;
      loop_o  <= 1'b0;
      order_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (mask_i == '0) begin
              done_o  <= 1'b1;
              loop_o  <= 1'b0;
              order_o <= '0;
            end else begin
              alive_q <= mask_i;
              step_q  <= '0;
              st_q    <= ST_PEEL;
            end
          end
        end
        ST_PEEL: begin
          if (sinks_i == '0) begin
            done_o  <= 1'b1;
            loop_o  <= 1'b1;
            order_o <= step_q;
            st_q    <= ST_IDLE;
          end else begin
            alive_q <= left_d;
            step_q  <= step_inc;
            if (left_d == '0) begin
              done_o  <= 1'b1;
              loop_o  <= 1'b0;
              order_o <= step_inc;
              st_q    <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign alive_o = alive_q;
  assign busy_o  = (st_q == ST_PEEL);
endmodule

// File: rtl/dag_round_checker.sv
module dag_round_checker #(
  parameter int P = 8,
  localparam int IW = (P > 1) ? $clog2(P) : 1,
  localparam int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [P-1:0]  ld_row_i,
  input  logic          start_i,
  input  logic [P-1:0]  node_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          loop_o,
  output logic [CW-1:0] order_o
);
  logic [P-1:0][P-1:0] rows;
  logic [P-1:0]        alive;
  logic [P-1:0]        sinks;
  logic                busy;

  adj_row_store #(.P(P), .IW(IW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we_i   (ld_en_i & ~busy),
    .widx_i (ld_idx_i),
    .wrow_i (ld_row_i),
    .rows_o (rows)
  );

  sink_finder #(.P(P)) u_sinks (
    .rows_i  (rows),
    .alive_i (alive),
    .sinks_o (sinks)
  );

  peel_ctrl #(.P(P), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .mask_i  (node_mask_i),
    .sinks_i (sinks),
    .alive_o (alive),
    .busy_o  (busy),
    .done_o  (done_o),
    .loop_o  (loop_o),
    .order_o (order_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/dag_round_checker_sva.sv
module dag_round_checker_sva #(
  parameter int P = 8,
  localparam int CW = $clog2(P + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          loop_o,
  input logic [CW-1:0] order_o
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  p_hold_result_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(loop_o) && $stable(order_o)));

  p_order_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !loop_o) |-> (int'(order_o) <= P));
endmodule

bind dag_round_checker dag_round_checker_sva #(.P(P)) u_sva (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .loop_o  (loop_o),
  .order_o (order_o)
);

// File: tb/dag_round_checker_tb_top.sv
module dag_round_checker_tb_top;
  localparam int P  = 8;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int NV = 10;

  // row of node i in bits [8i+7:8i]
  localparam logic [63:0] V_ROWS [NV] = '{
    64'h0000_0020_2210_1428,   // worked six-node graph
    64'h0080_4020_1008_0402,   // chain 0->1->..->7
    64'h0000_0000_0000_0102,   // 0<->1
    64'h0000_0000_0004_0000,   // self-arc on node 2
    64'h0000_0000_0000_0000,   // no arcs
    64'h0000_0000_0000_00FE,   // arcs only to masked-out nodes
    64'h0000_0000_0000_0102,   // cycle among masked-out nodes
    64'h0000_0000_0008_0806,   // diamond
    64'h0000_0000_0000_0502,   // cycle found after one step
    64'h8000_0000_0000_0000    // self-arc on node 7 among free nodes
  };
  localparam logic [7:0] V_MASK [NV] = '{8'h3F, 8'hFF, 8'h03, 8'h04, 8'hFF,
                                         8'h01, 8'h10, 8'h0F, 8'h07, 8'hFF};
  localparam logic V_LOOP [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                                   1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int V_ORD [NV] = '{6, 8, 0, 0, 1, 1, 1, 3, 1, 1};
  localparam int V_LAT [NV] = '{6, 8, 1, 1, 1, 1, 1, 3, 2, 2};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en_i = 1'b0;
  logic [IW-1:0] ld_idx_i = '0;
  logic [P-1:0]  ld_row_i = '0;
  logic          start_i = 1'b0;
  logic [P-1:0]  node_mask_i = '0;
  logic          busy_o, done_o, loop_o;
  logic [CW-1:0] order_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dag_round_checker #(.P(P)) dut_i (
    .clk(clk), .rst(rst), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_row_i(ld_row_i), .start_i(start_i), .node_mask_i(node_mask_i),
    .busy_o(busy_o), .done_o(done_o), .loop_o(loop_o), .order_o(order_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_rows(input logic [63:0] r);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      ld_en_i  = 1'b1;
      ld_idx_i = IW'(i);
      ld_row_i = r[8*i +: 8];
    end
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  // pulse start, return number of cycles until done is seen
  task automatic run(input logic [7:0] m, output int lat);
    @(negedge clk);
    start_i = 1'b1;
    node_mask_i = m;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy_o == 1'b0 && done_o == 1'b0, "R11 busy/done in reset", int'(busy_o) + int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(loop_o == 1'b0 && order_o == '0, "R11 results after reset", int'(order_o) + int'(loop_o), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      load_rows(V_ROWS[v]);
      run(V_MASK[v], lat);
      chk(done_o == 1'b1, $sformatf("R3 case %0d done seen", v), int'(done_o), 1);
      chk(loop_o == V_LOOP[v], $sformatf("R4 R7 case %0d loop flag", v), int'(loop_o), int'(V_LOOP[v]));
      chk(lat == V_LAT[v], $sformatf("R3 R5 case %0d latency", v), lat, V_LAT[v]);
      if (!V_LOOP[v])
        chk(int'(order_o) == V_ORD[v], $sformatf("R2 R5 R6 case %0d order", v), int'(order_o), V_ORD[v]);
      @(negedge clk);
      chk(done_o == 1'b0, $sformatf("R10 case %0d done one cycle", v), int'(done_o), 0);
    end

    // R8 empty mask
    run(8'h00, lat);
    chk(lat == 0 && done_o, "R8 empty mask latency", lat, 0);
    chk(loop_o == 1'b0 && order_o == '0, "R8 empty mask result", int'(order_o) + int'(loop_o), 0);
    chk(busy_o == 1'b0, "R8 busy stays low", int'(busy_o), 0);

    // R9 and R1: start and load during a busy chain run are ignored
    load_rows(V_ROWS[1]);
    @(negedge clk);
    start_i = 1'b1;
    node_mask_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b1;            // second start while busy
    node_mask_i = 8'h01;
    ld_en_i  = 1'b1;           // would close 7->0 into a cycle
    ld_idx_i = 3'd7;
    ld_row_i = 8'h01;
    @(negedge clk);
    start_i = 1'b0;
    ld_en_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 8, "R9 busy start ignored latency", lat, 8);
    chk(loop_o == 1'b0 && int'(order_o) == 8, "R9 busy start ignored result", int'(order_o), 8);
    // R10 results hold while idle
    repeat (3) @(negedge clk);
    chk(int'(order_o) == 8 && !loop_o && !done_o, "R10 result held", int'(order_o), 8);
    // R1 rerun without reload: row 7 still empty
    run(8'hFF, lat);
    chk(loop_o == 1'b0 && int'(order_o) == 8, "R1 busy load discarded", int'(order_o), 8);

    // R1 idle load takes effect: now 7->0 closes the chain
    load_rows(64'h0180_4020_1008_0402);
    run(8'hFF, lat);
    chk(loop_o == 1'b1 && lat == 1, "R1 idle load stored", int'(loop_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule